// File: doc/BRIEF.md
# Memory Module Presence-Detect Target

This block is a two-wire (I2C) target that imitates the small identification memory carried by a 168-pin SDRAM module. A board-level controller uses it to learn the size and shape of the fitted memory. The target answers at a 7-bit bus address of 0x50 plus a 3-bit slot strap, so each memory slot on a board appears at its own address. The 256-byte table it serves is generated from a capacity select input and is not stored as a memory array.

The host sets a read pointer by writing one byte (the subaddress) after an addressed write. It can then issue a repeated START with a read address and clock out bytes one after another. The pointer starts again at zero at every transaction that follows a STOP. The table reports 128 bytes present, so the pointer wraps to zero before it returns any entry at or beyond that count. Further data bytes written after the subaddress are acknowledged and thrown away. SCL and SDA are sampled on the system clock through synchronisers, and SDA is driven open-drain through an output-enable pin.

Top module: `spd_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 0x50 + slot_strap. For any other address, SDA stays released during the acknowledge bit.
- R2: Table entries 0, 1 and 2 read as 128 (bytes present), 8 (log2 of the table size) and 4 (SDRAM type code).
- R3: Entries 3, 4 and 5 (row bits, column bits, banks) follow cap_sel. The codes are 0 = 32 MB: 12/8/1, 1 = 64 MB: 12/9/1, 2 = 128 MB: 12/10/1 and 3 = 256 MB: 12/10/2.
- R4: A cap_sel value of 4 to 7 drives cap_err high, and entries 3 to 5 then read as 0. For codes 0 to 3, cap_err is low.
- R5: Entries 6 to 255 read as 0x00.
- R6: A START that follows reset or a STOP sets the read pointer to 0, so a plain read returns entry 0 first.
- R7: The first data byte after an addressed write (R/W bit 0) is loaded into the read pointer. A repeated START followed by a read keeps that pointer value.
- R8: Each byte read returns the entry at the pointer and then advances the pointer by one.
- R9: Before a byte is returned, a pointer of 128 or more is replaced by 0. Reading on from 126 therefore gives entries 126, 127, 0 and 1.
- R10: Every data byte written after the subaddress is acknowledged and leaves the table unchanged.
- R11: A read byte that the host does not acknowledge ends the transfer. The target keeps SDA released until the next START and changes SDA only while SCL is low.
- R12: At reset and after a STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| slot_strap | input | 3 | Slot address strap added to 0x50 |
| cap_sel | input | 3 | Module capacity code |
| cap_err | output | 1 | High when cap_sel is not a supported code |

## Verification
The hardest case to reach is the wrap boundary combined with a pointer that survives a repeated START. The host must first write a subaddress near or beyond the byte count, then re-address for reading without a STOP, and then clock across entry 127. Directed transactions load subaddresses 126 and 200 this way. Random transactions draw subaddresses from the full 0 to 255 range, random burst lengths and random capacity codes, so that the sequence model in the bench also meets the boundary from other starting points.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_BYTE,
        PH_WR_ACK,
        PH_RD_BYTE,
        PH_RD_ACK
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic [7:0] ptr;
        logic       rd_mode;
        logic       sub_pend;
        logic       busy;
        logic       host_ack;
        logic       oe;
    } link_s;

    typedef struct packed {
        logic [7:0] rows;
        logic [7:0] cols;
        logic [7:0] banks;
        logic       bad;
    } geom_s;

    function automatic geom_s geometry(input logic [2:0] code);
        geom_s g;
        g = '{rows: 8'd0, cols: 8'd0, banks: 8'd0, bad: 1'b1};
        case (code)
            3'd0: g = '{rows: 8'd12, cols: 8'd8,  banks: 8'd1, bad: 1'b0};
            3'd1: g = '{rows: 8'd12, cols: 8'd9,  banks: 8'd1, bad: 1'b0};
            3'd2: g = '{rows: 8'd12, cols: 8'd10, banks: 8'd1, bad: 1'b0};
            3'd3: g = '{rows: 8'd12, cols: 8'd10, banks: 8'd2, bad: 1'b0};
            default: g = '{rows: 8'd0, cols: 8'd0, banks: 8'd0, bad: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/spd_bus_sampler.sv
module spd_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_p;
        logic                   sda_p;
    } samp_s;

    samp_s d, q;
    logic  scl_cur;

    // the sync chain is built stage by stage
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_comb begin
                d.scl_sync[0] = scl_i;
                d.sda_sync[0] = sda_i;
            end
        end else begin : g_next
            always_comb begin
                d.scl_sync[s] = q.scl_sync[s-1];
                d.sda_sync[s] = q.sda_sync[s-1];
            end
        end
    end

    always_comb begin
        d.scl_p = q.scl_sync[LAST];
        d.sda_p = q.sda_sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        scl_cur   = q.scl_sync[LAST];
        sda_s     = q.sda_sync[LAST];
        scl_rise  = scl_cur & ~q.scl_p;
        scl_fall  = ~scl_cur & q.scl_p;
        start_evt = scl_cur & q.scl_p & q.sda_p & ~sda_s;
        stop_evt  = scl_cur & q.scl_p & ~q.sda_p & sda_s;
    end

endmodule

// File: rtl/spd_content.sv
module spd_content
    import spd_pkg::*;
#(
    parameter int BYTE_COUNT = 128,
    parameter int LOG2_SIZE  = 8,
    parameter int MEM_TYPE   = 4
) (
    input  logic [7:0] idx,
    input  logic [2:0] cap_sel,
    output logic [7:0] data,
    output logic       cap_err
);
    localparam logic [7:0] COUNT_B = 8'(BYTE_COUNT);
    localparam logic [7:0] LOG2_B  = 8'(LOG2_SIZE);
    localparam logic [7:0] TYPE_B  = 8'(MEM_TYPE);

    geom_s g;

    always_comb begin
        g       = geometry(cap_sel);
        cap_err = g.bad;
        case (idx)
            8'd0:    data = COUNT_B;
            8'd1:    data = LOG2_B;
            8'd2:    data = TYPE_B;
            8'd3:    data = g.rows;
            8'd4:    data = g.cols;
            8'd5:    data = g.banks;
            default: data = 8'h00;
        endcase
    end

endmodule

// File: rtl/spd_link_fsm.sv
module spd_link_fsm
    import spd_pkg::*;
#(
    parameter logic [6:0] DEV_BASE   = 7'h50,
    parameter int         BYTE_COUNT = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [2:0] slot_strap,
    input  logic [7:0] rom_data,
    output logic [7:0] rom_idx,
    output logic [7:0] ptr_q,
    output logic       rd_load,
    output logic       sda_oe
);
    localparam logic [7:0] COUNT_B = 8'(BYTE_COUNT);
    localparam logic [3:0] BITS    = 4'd8;

    link_s      d, q;
    logic [7:0] eff_ptr;
    logic [6:0] dev_addr;
    logic       do_load;

    always_comb begin
        dev_addr = DEV_BASE + {4'b0000, slot_strap};
        eff_ptr  = (q.ptr >= COUNT_B) ? 8'd0 : q.ptr;
        rom_idx  = eff_ptr;
        d        = q;
        do_load  = 1'b0;

        if (stop_evt) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
            d.busy  = 1'b0;
        end else if (start_evt) begin
            d.phase = PH_ADDR;
            d.cnt   = 4'd0;
            d.oe    = 1'b0;
            d.busy  = 1'b1;
            if (!q.busy) begin
                d.ptr = 8'd0;
            end
        end else begin
            case (q.phase)
                PH_ADDR, PH_WR_BYTE: begin
                    if (scl_rise && q.cnt < BITS) begin
                        d.shreg = {q.shreg[6:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        if (q.phase == PH_ADDR) begin
                            if (q.shreg[7:1] == dev_addr) begin
                                d.phase    = PH_ADDR_ACK;
                                d.oe       = 1'b1;
                                d.rd_mode  = q.shreg[0];
                                d.sub_pend = ~q.shreg[0];
                            end else begin
                                d.phase = PH_IDLE;
                            end
                        end else begin
                            d.phase = PH_WR_ACK;
                            d.oe    = 1'b1;
                            if (q.sub_pend) begin
                                d.ptr      = q.shreg;
                                d.sub_pend = 1'b0;
                            end
                        end
                    end
                end
                PH_ADDR_ACK, PH_WR_ACK: begin
                    if (scl_fall) begin
                        if (q.phase == PH_ADDR_ACK && q.rd_mode) begin
                            do_load = 1'b1;
                        end else begin
                            d.phase = PH_WR_BYTE;
                            d.cnt   = 4'd0;
                            d.oe    = 1'b0;
                        end
                    end
                end
                PH_RD_BYTE: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe    = 1'b0;
                            d.phase = PH_RD_ACK;
                        end else begin
                            d.cnt   = q.cnt + 4'd1;
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (scl_rise) begin
                        d.host_ack = ~sda_s;
                    end
                    if (scl_fall) begin
                        if (q.host_ack) begin
                            do_load = 1'b1;
                        end else begin
                            d.phase = PH_IDLE;
                            d.oe    = 1'b0;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end

        if (do_load) begin
            d.phase = PH_RD_BYTE;
            d.cnt   = 4'd0;
            d.shreg = rom_data;
            d.oe    = ~rom_data[7];
            d.ptr   = eff_ptr + 8'd1;
        end
        rd_load = do_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: 4'd0, shreg: 8'd0, ptr: 8'd0,
                   rd_mode: 1'b0, sub_pend: 1'b0, busy: 1'b0,
                   host_ack: 1'b0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign ptr_q  = q.ptr;

endmodule

// File: rtl/spd_i2c_target.sv
module spd_i2c_target #(
    parameter logic [6:0] DEV_BASE    = 7'h50,
    parameter int         BYTE_COUNT  = 128,
    parameter int         LOG2_SIZE   = 8,
    parameter int         MEM_TYPE    = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] slot_strap,
    input  logic [2:0] cap_sel,
    output logic       cap_err
);
    logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0] rom_idx, rom_data, ptr_q;
    logic       rd_load;

    spd_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    spd_content #(
        .BYTE_COUNT (BYTE_COUNT),
        .LOG2_SIZE  (LOG2_SIZE),
        .MEM_TYPE   (MEM_TYPE)
    ) u_rom (
        .idx     (rom_idx),
        .cap_sel (cap_sel),
        .data    (rom_data),
        .cap_err (cap_err)
    );

    spd_link_fsm #(
        .DEV_BASE   (DEV_BASE),
        .BYTE_COUNT (BYTE_COUNT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .slot_strap (slot_strap),
        .rom_data   (rom_data),
        .rom_idx    (rom_idx),
        .ptr_q      (ptr_q),
        .rd_load    (rd_load),
        .sda_oe     (sda_oe)
    );

endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
    parameter int BYTE_COUNT = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       rd_load,
    input logic [7:0] ptr_q,
    input logic [7:0] rom_idx,
    input logic [7:0] rom_data,
    input logic       cap_err
);
    localparam logic [7:0] COUNT_B = 8'(BYTE_COUNT);

    // R11: the target only starts pulling SDA while SCL is low
    a_r11_pull_when_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R12: a STOP leaves the line released
    a_r12_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R6: a START leaves the line released for the address phase
    a_r6_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt && !stop_evt |=> !sda_oe);

    // R9: after serving a byte the pointer lies in 1..byte count
    a_r9_ptr_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (ptr_q >= 8'd1 && ptr_q <= COUNT_B));

    // R9: the served index is always below the byte count
    a_r9_index_below_count: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> rom_idx < COUNT_B);

    // R4: an unsupported code blanks the geometry entries
    a_r4_blank_geometry: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_err && rom_idx >= 8'd3 && rom_idx <= 8'd5) |-> rom_data == 8'd0);

endmodule

bind spd_i2c_target spd_checker #(.BYTE_COUNT(BYTE_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_load   (rd_load),
    .ptr_q     (ptr_q),
    .rom_idx   (rom_idx),
    .rom_data  (rom_data),
    .cap_err   (cap_err)
);

// File: tb/tb_spd_i2c_target.sv
module tb_spd_i2c_target;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic [2:0] slot_strap = 3'd0;
    logic [2:0] cap_sel = 3'd1;
    logic       scl_w, sda_w, sda_oe, cap_err;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    assign scl_w = ~m_scl_low;
    assign sda_w = ~(m_sda_low | sda_oe);

    spd_i2c_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_w),
        .sda_i      (sda_w),
        .sda_oe     (sda_oe),
        .slot_strap (slot_strap),
        .cap_sel    (cap_sel),
        .cap_err    (cap_err)
    );

    function automatic logic [7:0] exp_byte(input int idx, input logic [2:0] cap);
        logic [7:0] r;
        r = 8'd0;
        if (idx == 0) r = 8'd128;
        else if (idx == 1) r = 8'd8;
        else if (idx == 2) r = 8'd4;
        else if (idx == 3) r = (cap < 3'd4) ? 8'd12 : 8'd0;
        else if (idx == 4) r = (cap == 3'd0) ? 8'd8 : (cap == 3'd1) ? 8'd9 :
                               (cap < 3'd4) ? 8'd10 : 8'd0;
        else if (idx == 5) r = (cap == 3'd3) ? 8'd2 : (cap < 3'd3) ? 8'd1 : 8'd0;
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq(Q);
        m_scl_low = 1'b0; wq(Q);
        m_sda_low = 1'b1; wq(Q);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq(Q);
        m_scl_low = 1'b0; wq(Q);
        m_sda_low = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; wq(Q);
            m_scl_low = 1'b0;  wq(2*Q);
            m_scl_low = 1'b1;  wq(Q);
        end
        m_sda_low = 1'b0; wq(Q);
        m_scl_low = 1'b0; wq(Q);
        acked = ~sda_w;   wq(Q);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = 1'b0; wq(Q);
            m_scl_low = 1'b0; wq(Q);
            b[i] = sda_w;     wq(Q);
            m_scl_low = 1'b1; wq(Q);
        end
        m_sda_low = give_ack; wq(Q);
        m_scl_low = 1'b0;     wq(2*Q);
        m_scl_low = 1'b1;     wq(Q);
        m_sda_low = 1'b0;
    endtask

    // subaddress write, then repeated START and n reads checked against model
    task automatic sub_then_read(input logic [7:0] sub, input int n, input string req);
        logic       a;
        logic [7:0] b;
        int         p;
        bus_start();
        send_byte({7'h50 + {4'b0, slot_strap}, 1'b0}, a);
        chk(a, "R1 write address ack", a, 1);
        send_byte(sub, a);
        chk(a, "R7 subaddress ack", a, 1);
        bus_start();
        send_byte({7'h50 + {4'b0, slot_strap}, 1'b1}, a);
        chk(a, "R7 read address ack", a, 1);
        p = int'(sub);
        for (int k = 0; k < n; k++) begin
            if (p >= 128) p = 0;
            recv_byte(k != n - 1, b);
            chk(b == exp_byte(p, cap_sel), req, b, exp_byte(p, cap_sel));
            p++;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] b;
        int         n, sub;
        void'($urandom(32'd1234));
        wq(4);
        chk(sda_oe == 1'b0, "R12 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        wq(4);
        chk(sda_oe == 1'b0, "R12 released after reset", sda_oe, 0);
        chk(cap_err == 1'b0, "R4 code 1 accepted", cap_err, 0);

        // R6 R2 R3 R8: plain read from a fresh transaction
        slot_strap = 3'd3;
        bus_start();
        send_byte({7'h53, 1'b1}, a);
        chk(a, "R1 match 0x53", a, 1);
        for (int k = 0; k < 6; k++) begin
            recv_byte(k != 5, b);
            chk(b == exp_byte(k, 3'd1), "R6 R2 R3 R8 sequential read", b, exp_byte(k, 3'd1));
        end
        bus_stop();

        // R1: wrong address is not acknowledged
        bus_start();
        send_byte({7'h52, 1'b1}, a);
        chk(!a, "R1 mismatch nack", a, 0);
        bus_stop();

        // R9: wrap across the byte count, and R5 zero fill
        sub_then_read(8'd126, 4, "R9 R5 wrap from 126");
        sub_then_read(8'd200, 2, "R9 pointer beyond count");
        sub_then_read(8'd6, 2, "R5 zero fill");

        // R10: written data acked and ignored
        bus_start();
        send_byte({7'h53, 1'b0}, a);
        send_byte(8'd3, a);
        send_byte(8'hFF, a);
        chk(a, "R10 data ack", a, 1);
        send_byte(8'h55, a);
        chk(a, "R10 second data ack", a, 1);
        bus_stop();
        chk(sda_oe == 1'b0, "R12 released after stop", sda_oe, 0);
        sub_then_read(8'd3, 3, "R10 table unchanged");

        // R4: unsupported code
        cap_sel = 3'd5;
        wq(2);
        chk(cap_err == 1'b1, "R4 error flag", cap_err, 1);
        sub_then_read(8'd3, 3, "R4 blank geometry");
        cap_sel = 3'd3;
        wq(2);
        chk(cap_err == 1'b0, "R4 code 3 accepted", cap_err, 0);
        sub_then_read(8'd3, 3, "R3 256 MB geometry");

        // R11: host NACK then extra clocks must read released line
        bus_start();
        send_byte({7'h53, 1'b1}, a);
        recv_byte(1'b0, b);
        chk(b == 8'd128, "R11 first byte", b, 128);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R11 released after nack", b, 255);
        bus_stop();

        // random transactions
        for (int t = 0; t < 30; t++) begin
            cap_sel    = 3'($urandom_range(0, 3));
            slot_strap = 3'($urandom_range(0, 7));
            sub        = int'($urandom_range(0, 255));
            if (t < 6) sub = 124 + t;
            n          = int'($urandom_range(1, 4));
            sub_then_read(8'(sub), n, "R7 R8 R9 random read");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule